// File: doc/BRIEF.md
# Paired Transmit/Receive Word Queues with DMA Request Thresholds

This block holds two small word queues that sit between a host bus and a serial shift engine. The transmit queue is filled by the host and drained by the shift engine. The receive queue is filled by the shift engine and drained by the host. Each queue has a programmable threshold that drives a level-sensitive DMA request. For transmit, the request means "there is room to refill". For receive, it means "there is data to collect". Each direction has its own enable that gates its request.

Each queue reports its occupancy on a count output. A single-cycle clear strobe empties a queue, and that strobe wins over any push or pop in the same cycle. The block records three sticky error events: an empty-queue read on the transmit side, a push into a full receive queue, and a host push into a full transmit queue. These flags stay set until reset.

Every output is registered. Memory writes carry no reset, so the storage can map onto distributed or block RAM.

Top module: `dma_fifo_pair`

## Requirements
- R1: After a synchronous reset, both counts, both DMA requests, all three error flags and both read-data outputs are zero.
- R2: Each queue holds DEPTH (default 8) words. Its count output equals the number of stored words, 0 to DEPTH, from the edge at which a push or pop is taken. A push is accepted only if the queue was not full at the start of the cycle, and a pop is served only if it was not empty, so a push and a pop can complete in the same cycle.
- R3: The transmit request is high in a cycle exactly when, at the previous edge, the transmit enable was 1 and the free entries (DEPTH minus count) are now at least the transmit level value plus one. The level is a 3-bit field, 0 to 7.
- R4: The receive request is high exactly when, at the previous edge, the receive enable was 1 and the filled entries are now at least the receive level value plus one.
- R5: When a direction's enable is 0, its request is 0 from the next edge onward, whatever the count and the level.
- R6: A 1 on a clear input empties that queue at the next edge. The clear is a strobe: the queue works normally in the following cycle with no further action.
- R7: A clear has priority over a push or pop in the same cycle. The push is not stored, the pop returns nothing (read data holds its value), and no error flag is set by that push or pop.
- R8: A transmit pop from an empty queue sets the read data to zero and sets the transmit underrun flag. A receive pop from an empty queue sets its read data to zero and sets no flag.
- R9: A push into a full receive queue drops the word and sets the receive overrun flag.
- R10: A host push into a full transmit queue drops the word and sets the transmit overrun flag.
- R11: The three error flags are sticky. Once set, they stay 1 until reset.
- R12: A served pop presents the oldest stored word on that queue's read data at the next edge. Words leave in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Host writes a word into the transmit queue |
| tx_wdata | input | DATA_W | Word written by the host |
| tx_pop | input | 1 | Shift engine takes a word from the transmit queue |
| tx_rdata | output | DATA_W | Word taken by the last transmit pop (zero on underrun) |
| rx_push | input | 1 | Shift engine writes a received word |
| rx_wdata | input | DATA_W | Received word |
| rx_pop | input | 1 | Host takes a word from the receive queue |
| rx_rdata | output | DATA_W | Word taken by the last receive pop |
| tx_clear | input | 1 | Strobe that empties the transmit queue |
| rx_clear | input | 1 | Strobe that empties the receive queue |
| tx_level | input | LVL_W | Transmit threshold: request when free entries exceed this value |
| rx_level | input | LVL_W | Receive threshold: request when filled entries exceed this value |
| tx_dma_en | input | 1 | Enables the transmit DMA request |
| rx_dma_en | input | 1 | Enables the receive DMA request |
| tx_count | output | CNT_W | Words held in the transmit queue |
| rx_count | output | CNT_W | Words held in the receive queue |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_underrun | output | 1 | Sticky: transmit pop while empty |
| rx_overrun | output | 1 | Sticky: receive push while full |
| tx_overrun | output | 1 | Sticky: transmit push while full |

## Verification
The bench targets a full queue that sees a push and a pop in the same cycle. A design that judged fullness after the pop would store the word and miss the overrun flag. It also targets an empty transmit queue that sees both at once, where a design that bypassed the new word to the reader would miss the underrun. The level sweep reaches both ends: level 7 on an empty transmit queue must request, and level 0 with a single received word must request. An off-by-one in the "plus one" encoding shows up as a request one entry early or late. Clears that coincide with pushes and pops expose a design that lets the stale operation store a word or raise a flag. Long mixed traffic with changing levels and enables exposes pointer-wrap and ordering errors as wrong read data.

// File: rtl/fq_pkg.sv
package fq_pkg;

  // Error events raised by the two queues in one cycle.
  typedef struct packed {
    logic tx_ovr;
    logic rx_ovr;
    logic tx_unf;
  } fq_evt_t;

  localparam int FQ_EVT_N = $bits(fq_evt_t);

  // Threshold encoding: a level field L asks for at least L+1 entries.
  function automatic int fq_need(input int level);
    return level + 1;
  endfunction

endpackage

// File: rtl/fq_fifo.sv
module fq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          push_drop,
  output logic          pop_empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          is_full, is_empty, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  assign is_full   = (count == FULL_CNT);
  assign is_empty  = (count == '0);
  assign do_push   = push && !clr && !is_full;
  assign do_pop    = pop  && !clr && !is_empty;
  assign push_drop = push && !clr &&  is_full;
  assign pop_empty = pop  && !clr &&  is_empty;

  always_comb begin
    if (clr) begin
      count_nxt = '0;
    end else begin
      count_nxt = count;
      if (do_push && !do_pop) count_nxt = count + CW'(1);
      if (do_pop && !do_push) count_nxt = count - CW'(1);
    end
  end

  // Storage has no reset so it can map onto RAM resources.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)            rdata <= '0;
    else if (do_pop)    rdata <= mem[rd_ptr];
    else if (pop_empty) rdata <= '0;
  end

endmodule

// File: rtl/fq_dma_req.sv
module fq_dma_req #(
  parameter int DEPTH      = 8,
  parameter int CW         = $clog2(DEPTH + 1),
  parameter int LW         = 3,
  parameter bit FREE_BASED = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] level,
  input  logic [CW-1:0] count_nxt,
  output logic          req
);

  localparam int XW = ((CW > LW) ? CW : LW) + 1;

  logic [XW-1:0] need;
  logic [XW-1:0] have;
  logic          hit;

  assign need = XW'(fq_pkg::fq_need(int'(level)));

  generate
    if (FREE_BASED) begin : g_free
      assign have = XW'(DEPTH) - XW'(count_nxt);
    end else begin : g_fill
      assign have = XW'(count_nxt);
    end
  endgenerate

  assign hit = (have >= need);

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= en && hit;
  end

endmodule

// File: rtl/fq_sticky.sv
module fq_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag
);

  always_ff @(posedge clk) begin
    if (rst) flag <= '0;
    else     flag <= flag | set;
  end

endmodule

// File: rtl/dma_fifo_pair.sv
module dma_fifo_pair #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_rdata,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic              tx_clear,
  input  logic              rx_clear,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_dma_en,
  input  logic              rx_dma_en,
  output logic [CNT_W-1:0]  tx_count,
  output logic [CNT_W-1:0]  rx_count,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              tx_underrun,
  output logic              rx_overrun,
  output logic              tx_overrun
);

  import fq_pkg::*;

  logic [CNT_W-1:0] tx_cnt_nxt, rx_cnt_nxt;
  logic             tx_drop, tx_empty_pop, rx_drop, rx_empty_pop;
  fq_evt_t          evt, flags;

  fq_fifo #(.DW(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clear),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
    .count(tx_count), .count_nxt(tx_cnt_nxt),
    .push_drop(tx_drop), .pop_empty(tx_empty_pop)
  );

  fq_fifo #(.DW(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clear),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
    .count(rx_count), .count_nxt(rx_cnt_nxt),
    .push_drop(rx_drop), .pop_empty(rx_empty_pop)
  );

  fq_dma_req #(.DEPTH(DEPTH), .CW(CNT_W), .LW(LVL_W), .FREE_BASED(1'b1)) u_txreq (
    .clk(clk), .rst(rst), .en(tx_dma_en), .level(tx_level),
    .count_nxt(tx_cnt_nxt), .req(tx_dma_req)
  );

  fq_dma_req #(.DEPTH(DEPTH), .CW(CNT_W), .LW(LVL_W), .FREE_BASED(1'b0)) u_rxreq (
    .clk(clk), .rst(rst), .en(rx_dma_en), .level(rx_level),
    .count_nxt(rx_cnt_nxt), .req(rx_dma_req)
  );

  // Receive pops from an empty queue carry no flag.
  logic unused_rx_empty_pop;
  assign unused_rx_empty_pop = rx_empty_pop;

  always_comb begin
    evt        = '0;
    evt.tx_ovr = tx_drop;
    evt.rx_ovr = rx_drop;
    evt.tx_unf = tx_empty_pop;
  end

  fq_sticky #(.N(FQ_EVT_N)) u_flags (
    .clk(clk), .rst(rst), .set(evt), .flag(flags)
  );

  assign tx_underrun = flags.tx_unf;
  assign rx_overrun  = flags.rx_ovr;
  assign tx_overrun  = flags.tx_ovr;

endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int LVL_W  = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_push,
  input logic [DATA_W-1:0] tx_wdata,
  input logic              tx_pop,
  input logic [DATA_W-1:0] tx_rdata,
  input logic              rx_push,
  input logic [DATA_W-1:0] rx_wdata,
  input logic              rx_pop,
  input logic [DATA_W-1:0] rx_rdata,
  input logic              tx_clear,
  input logic              rx_clear,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              tx_dma_en,
  input logic              rx_dma_en,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count,
  input logic              tx_dma_req,
  input logic              rx_dma_req,
  input logic              tx_underrun,
  input logic              rx_overrun,
  input logic              tx_overrun
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (tx_count == '0 && rx_count == '0 && !tx_dma_req && !rx_dma_req &&
             !tx_underrun && !rx_overrun && !tx_overrun));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_count) <= DEPTH) && (int'(rx_count) <= DEPTH));

  a_r3_tx_req_room: assert property (@(posedge clk) disable iff (rst)
    tx_dma_req |-> ((DEPTH - int'(tx_count)) >= (int'($past(tx_level)) + 1)));

  a_r4_rx_req_fill: assert property (@(posedge clk) disable iff (rst)
    rx_dma_req |-> (int'(rx_count) >= (int'($past(rx_level)) + 1)));

  a_r5_tx_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !tx_dma_en |=> !tx_dma_req);

  a_r5_rx_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !rx_dma_en |=> !rx_dma_req);

  a_r6_tx_clear_empties: assert property (@(posedge clk) disable iff (rst)
    tx_clear |=> (tx_count == '0));

  a_r6_rx_clear_empties: assert property (@(posedge clk) disable iff (rst)
    rx_clear |=> (rx_count == '0));

  a_r7_tx_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (tx_clear && (tx_push || tx_pop)) |=>
      ($stable(tx_underrun) && $stable(tx_overrun) && $stable(tx_rdata)));

  a_r7_rx_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (rx_clear && (rx_push || rx_pop)) |=> ($stable(rx_overrun) && $stable(rx_rdata)));

  a_r8_tx_underrun: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && !tx_clear && tx_count == '0) |=> (tx_underrun && tx_rdata == '0));

  a_r9_rx_overrun: assert property (@(posedge clk) disable iff (rst)
    (rx_push && !rx_clear && int'(rx_count) == DEPTH) |=> rx_overrun);

  a_r10_tx_overrun: assert property (@(posedge clk) disable iff (rst)
    (tx_push && !tx_clear && int'(tx_count) == DEPTH) |=> tx_overrun);

  a_r11_sticky_flags: assert property (@(posedge clk) disable iff (rst)
    (tx_underrun || rx_overrun || tx_overrun) |=>
      ((tx_underrun || !$past(tx_underrun)) && (rx_overrun || !$past(rx_overrun)) &&
       (tx_overrun || !$past(tx_overrun))));

endmodule

bind dma_fifo_pair fq_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_fq_checker (.*);

// File: tb/test_dma_fifo_pair.sv
`timescale 1ns/1ps
module test_dma_fifo_pair;

  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int LW    = 3;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [DW-1:0] tx_wdata = '0, rx_wdata = '0;
  logic          tx_clear = 0, rx_clear = 0, tx_dma_en = 0, rx_dma_en = 0;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic [DW-1:0] tx_rdata, rx_rdata;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_dma_req, rx_dma_req, tx_underrun, rx_overrun, tx_overrun;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  dma_fifo_pair #(.DATA_W(DW), .DEPTH(DEPTH), .LVL_W(LW)) i_dma_fifo_pair (
    .clk(clk), .rst(rst),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .tx_clear(tx_clear), .rx_clear(rx_clear),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun), .tx_overrun(tx_overrun)
  );

  // Behavioural reference model, updated on every clock edge.
  logic [DW-1:0] txq[$], rxq[$];
  logic [DW-1:0] m_tx_rd = '0, m_rx_rd = '0;
  logic          m_tx_req = 0, m_rx_req = 0, m_unf = 0, m_rovr = 0, m_tovr = 0;
  int            sz;

  always @(posedge clk) begin
    if (rst) begin
      txq.delete(); rxq.delete();
      m_tx_rd = '0; m_rx_rd = '0;
      m_tx_req = 0; m_rx_req = 0; m_unf = 0; m_rovr = 0; m_tovr = 0;
    end else begin
      if (tx_clear) txq.delete();
      else begin
        sz = txq.size();
        if (tx_pop) begin
          if (sz > 0) m_tx_rd = txq.pop_front();
          else begin m_tx_rd = '0; m_unf = 1; end
        end
        if (tx_push) begin
          if (sz < DEPTH) txq.push_back(tx_wdata);
          else m_tovr = 1;
        end
      end
      if (rx_clear) rxq.delete();
      else begin
        sz = rxq.size();
        if (rx_pop) begin
          if (sz > 0) m_rx_rd = rxq.pop_front();
          else m_rx_rd = '0;
        end
        if (rx_push) begin
          if (sz < DEPTH) rxq.push_back(rx_wdata);
          else m_rovr = 1;
        end
      end
      m_tx_req = tx_dma_en && ((DEPTH - txq.size()) >= (int'(tx_level) + 1));
      m_rx_req = rx_dma_en && (rxq.size() >= (int'(rx_level) + 1));
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2",  "tx_count",    32'(tx_count),    32'(txq.size()));
    chk("R2",  "rx_count",    32'(rx_count),    32'(rxq.size()));
    chk("R3",  "tx_dma_req",  32'(tx_dma_req),  32'(m_tx_req));
    chk("R4",  "rx_dma_req",  32'(rx_dma_req),  32'(m_rx_req));
    chk("R8",  "tx_underrun", 32'(tx_underrun), 32'(m_unf));
    chk("R9",  "rx_overrun",  32'(rx_overrun),  32'(m_rovr));
    chk("R10", "tx_overrun",  32'(tx_overrun),  32'(m_tovr));
    chk("R12", "tx_rdata",    32'(tx_rdata),    32'(m_tx_rd));
    chk("R12", "rx_rdata",    32'(rx_rdata),    32'(m_rx_rd));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; tx_clear = 0; rx_clear = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    rst = 1; idle();
    repeat (3) cyc();
    rst = 0;
    chk("R1", "tx_count",  32'(tx_count), 0);
    chk("R1", "rx_count",  32'(rx_count), 0);
    chk("R1", "flags",     32'({tx_underrun, rx_overrun, tx_overrun}), 0);
    chk("R1", "reqs",      32'({tx_dma_req, rx_dma_req}), 0);
    chk("R1", "rdata",     32'({tx_rdata, rx_rdata}), 0);

    // R10: fill transmit queue, ninth push dropped
    for (int i = 0; i < DEPTH + 1; i++) begin
      tx_push = 1; tx_wdata = DW'(16'hA000 + i); cyc();
    end
    idle(); cyc();
    chk("R10", "tx_overrun after full push", 32'(tx_overrun), 1);
    chk("R2",  "tx_count full", 32'(tx_count), DEPTH);

    // R12 / R8: drain in order, then pop empty
    for (int i = 0; i < DEPTH; i++) begin
      tx_pop = 1; cyc();
      chk("R12", "tx order", 32'(tx_rdata), 32'(16'hA000 + i));
    end
    tx_pop = 1; cyc(); idle();
    chk("R8", "tx empty pop data", 32'(tx_rdata), 0);
    chk("R8", "tx underrun set", 32'(tx_underrun), 1);

    // R9: fill receive queue, ninth push dropped; drain
    for (int i = 0; i < DEPTH + 1; i++) begin
      rx_push = 1; rx_wdata = DW'(16'h5000 + i); cyc();
    end
    idle(); cyc();
    chk("R9", "rx_overrun after full push", 32'(rx_overrun), 1);
    for (int i = 0; i < DEPTH; i++) begin
      rx_pop = 1; cyc();
      chk("R12", "rx order", 32'(rx_rdata), 32'(16'h5000 + i));
    end
    rx_pop = 1; cyc(); idle();
    chk("R8", "rx empty pop data", 32'(rx_rdata), 0);

    // R3 / R4: threshold ends
    tx_dma_en = 1; tx_level = 3'd7; rx_dma_en = 1; rx_level = 3'd0; cyc();
    chk("R3", "tx req level7 empty", 32'(tx_dma_req), 1);
    chk("R4", "rx req level0 empty", 32'(rx_dma_req), 0);
    tx_push = 1; tx_wdata = 16'h1111; rx_push = 1; rx_wdata = 16'h2222; cyc(); idle();
    chk("R3", "tx req level7 one word", 32'(tx_dma_req), 0);
    chk("R4", "rx req level0 one word", 32'(rx_dma_req), 1);

    // R5: disabled directions stay quiet
    tx_dma_en = 0; rx_dma_en = 0; tx_level = 3'd0; cyc(); cyc();
    chk("R5", "tx req disabled", 32'(tx_dma_req), 0);
    chk("R5", "rx req disabled", 32'(rx_dma_req), 0);

    // R6 / R7: clear with concurrent push and pop
    for (int i = 0; i < 4; i++) begin tx_push = 1; tx_wdata = DW'(i); cyc(); end
    tx_push = 1; tx_pop = 1; tx_clear = 1; rx_push = 1; rx_pop = 1; rx_clear = 1; cyc(); idle();
    chk("R6", "tx count after clear", 32'(tx_count), 0);
    chk("R6", "rx count after clear", 32'(rx_count), 0);
    chk("R7", "tx rdata held on clear", 32'(tx_rdata), 32'(m_tx_rd));
    tx_push = 1; tx_wdata = 16'h7777; cyc(); idle(); tx_pop = 1; cyc(); idle();
    chk("R6", "tx works after clear", 32'(tx_rdata), 32'h7777);

    // R2: push and pop together on full and on empty queue
    for (int i = 0; i < DEPTH; i++) begin rx_push = 1; rx_wdata = DW'(16'h3000 + i); cyc(); end
    rx_push = 1; rx_pop = 1; rx_wdata = 16'hDEAD; cyc(); idle();
    chk("R2", "rx full push+pop count", 32'(rx_count), DEPTH - 1);
    rx_clear = 1; cyc(); idle();
    rst = 1; cyc(); rst = 0; idle();
    tx_push = 1; tx_pop = 1; tx_wdata = 16'hBEEF; cyc(); idle();
    chk("R2", "tx empty push+pop count", 32'(tx_count), 1);
    chk("R8", "tx empty push+pop underrun", 32'(tx_underrun), 1);

    // R11: flags persist across idle cycles, clear only on reset
    repeat (20) cyc();
    chk("R11", "tx underrun sticky", 32'(tx_underrun), 1);
    tx_clear = 1; cyc(); idle();
    chk("R11", "tx underrun survives clear", 32'(tx_underrun), 1);

    // Mixed traffic against the reference model
    for (int c = 0; c < 6000; c++) begin
      tx_push  = ($urandom % 100) < 45;
      tx_pop   = ($urandom % 100) < 40;
      rx_push  = ($urandom % 100) < 40;
      rx_pop   = ($urandom % 100) < 45;
      tx_wdata = DW'($urandom);
      rx_wdata = DW'($urandom);
      tx_clear = ($urandom % 200) == 0;
      rx_clear = ($urandom % 200) == 0;
      if (c % 64 == 0) begin
        tx_level  = LW'($urandom); rx_level  = LW'($urandom);
        tx_dma_en = ($urandom % 4) != 0; rx_dma_en = ($urandom % 4) != 0;
      end
      if (c % 1500 == 1499) rst = 1; else rst = 0;
      cyc();
    end
    rst = 0; idle(); cyc();
    finish_run();
  end

endmodule